// File: doc/BRIEF.md
# Resistive Touch X/Y/Z Sampler

This block shares one serial bus with a display streamer and, whenever it is handed that bus, reads one set of coordinates from a resistive touch controller. An internal interval timer decides when the next reading is due. At that point the block raises a slot request. The streamer finishes its current burst and answers with a one-cycle grant. The sampler then pulls the touch chip-select low and runs a fixed stream of 51 serial clocks. During that stream it shifts out a 51-bit command pattern, made of three 17-bit words, and it collects the reply bits that the touch chip returns.

The receive path does not count samples one at a time. Before the stream starts, the receive shifter is loaded with nine zero bits. The 51 captured bits then fill exactly four 15-bit frames, because 9 + 51 = 60 = 4 x 15. The first frame holds only padding and leading reply bits, so it is thrown away. The upper twelve bits of the second, third and fourth frames give the X, Y and Z readings.

When the stream ends, chip-select goes high and a done pulse returns the bus to the streamer. In the same cycle the three result registers change together and a one-cycle valid strobe is raised.

Top module: `touch_xyz_sampler`

## Requirements
- R1: While chip-select (`tpCsN`) is low, exactly 51 rising edges of `tpSck` occur. Whenever `tpCsN` is high, `tpSck` is low.
- R2: Each high phase and each low phase of `tpSck` lasts `HALF_DIV` system cycles. `tpCsN` stays low for exactly 102*`HALF_DIV` cycles. The default `HALF_DIV` of 40 keeps the serial clock at or below 2.5 MHz with a 200 MHz system clock.
- R3: `cmdStream` is latched at the grant. It is shifted out on `tpMosi` most significant bit first, one bit per serial clock. Bit `cmdStream[50-i]` is driven during serial cycle i, for i = 0 to 50. The first word is `cmdStream[50:34]`. Each bit is stable at the rising edge of `tpSck` and changes only after the falling edge.
- R4: `tpMiso` is sampled on every rising edge of `tpSck`. The receive path is cleared to nine zero bits before capture begins. The captured bits are framed into four 15-bit words, and the first word never reaches an output.
- R5: `sampleX` takes the bits sampled in serial cycles 6 to 17, `sampleY` those in cycles 21 to 32, and `sampleZ` those in cycles 36 to 47. In each case the earliest bit is the MSB. Bits sampled in any other cycle have no effect on the outputs.
- R6: `done` is high for exactly one cycle. That cycle is the first cycle in which `tpCsN` is high again after a transaction.
- R7: `sampleValid` is high for exactly one cycle, in the same cycle as `done`. `sampleX`, `sampleY` and `sampleZ` change only in that cycle, and they change together.
- R8: `slotReq` rises exactly `RATE_CYCLES` cycles after `done` is high. It then stays high until a grant is taken.
- R9: `slotGrant` has no effect while `slotReq` is low, and this includes the time during a transaction. A grant that arrives in that state neither starts a transaction nor stretches one.
- R10: During and right after reset, `tpCsN` is 1. `tpSck`, `tpMosi`, `slotReq`, `done` and `sampleValid` are 0, and all three results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotGrant | input | 1 | Bus slot handed over by the display streamer |
| cmdStream | input | 51 | Command pattern, three 17-bit words, first word in the top bits |
| tpMiso | input | 1 | Serial data from the touch controller |
| slotReq | output | 1 | Request for a bus slot |
| tpCsN | output | 1 | Touch controller chip-select, active low |
| tpSck | output | 1 | Serial clock to the touch controller |
| tpMosi | output | 1 | Serial data to the touch controller |
| done | output | 1 | One-cycle pulse that returns the bus to the streamer |
| sampleValid | output | 1 | One-cycle strobe marking new results |
| sampleX | output | 12 | X reading |
| sampleY | output | 12 | Y reading |
| sampleZ | output | 12 | Z reading |

## Verification
A transaction starts at the first clock edge at which a grant is seen with `slotReq` high. From that edge the serial rising edges fall at odd multiples of `HALF_DIV` and the falling edges at even multiples. `done`, `sampleValid` and the new results all appear 102*`HALF_DIV` cycles after the grant edge, and `slotReq` appears `RATE_CYCLES` cycles after that. The bench samples each port half a clock period after the edge. It reads `tpMosi` just after each serial rising edge, and it changes `tpMiso` just after each serial falling edge, so every bit has a full half-period to settle. The bench counts chip-select-low cycles and cycles from `done` to `slotReq`, and it compares those counts with the exact values above rather than with ranges. It checks `sampleValid` and result stability in the single cycle that follows `done`.

// File: rtl/touch_xyz_pkg.sv
package touch_xyz_pkg;

  // Per-cycle commands from the sequencer to the shift datapath
  typedef struct packed {
    logic load;     // grant taken: latch commands, clear receive path
    logic capture;  // serial rising edge: sample the input line
    logic advance;  // serial falling edge: present next command bit
    logic publish;  // stream finished: copy results out
  } tpStrobes_t;

  typedef enum logic [1:0] {
    TP_WAIT = 2'd0,
    TP_REQ  = 2'd1,
    TP_XFER = 2'd2
  } tpState_t;

endpackage

// File: rtl/touch_xyz_ctrl.sv
module touch_xyz_ctrl
  import touch_xyz_pkg::*;
#(
  parameter int HALF_DIV    = 40,
  parameter int RATE_CYCLES = 500000,
  parameter int XFER_BITS   = 51
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slotGrant,
  output logic       slotReq,
  output logic       tpCsN,
  output logic       tpSck,
  output logic       done,
  output tpStrobes_t strobes
);

  localparam int DIV_W  = $clog2(HALF_DIV + 1);
  localparam int RATE_W = $clog2(RATE_CYCLES + 1);
  localparam int BIT_W  = $clog2(XFER_BITS + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(HALF_DIV - 1);
  localparam logic [RATE_W-1:0] RATE_LOAD = RATE_W'(RATE_CYCLES - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(XFER_BITS - 1);

  tpState_t         state;
  logic [DIV_W-1:0] divCnt;
  logic [RATE_W-1:0] rateCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             phaseEnd;
  logic             lastBit;

  assign phaseEnd = (state == TP_XFER) && (divCnt == DIV_LAST);
  assign lastBit  = (bitIdx == BIT_LAST);

  always_comb begin
    strobes         = '0;
    strobes.load    = (state == TP_REQ) && slotGrant;
    strobes.capture = phaseEnd && !tpSck;
    strobes.advance = phaseEnd && tpSck && !lastBit;
    strobes.publish = phaseEnd && tpSck && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= TP_WAIT;
      rateCnt <= RATE_LOAD;
      divCnt  <= '0;
      bitIdx  <= '0;
      slotReq <= 1'b0;
      tpCsN   <= 1'b1;
      tpSck   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        TP_WAIT: begin
          if (rateCnt == '0) begin
            state   <= TP_REQ;
            slotReq <= 1'b1;
          end else begin
            rateCnt <= rateCnt - 1'b1;
          end
        end
        TP_REQ: begin
          if (slotGrant) begin
            state   <= TP_XFER;
            slotReq <= 1'b0;
            tpCsN   <= 1'b0;
            tpSck   <= 1'b0;
            divCnt  <= '0;
            bitIdx  <= '0;
          end
        end
        TP_XFER: begin
          if (divCnt == DIV_LAST) begin
            divCnt <= '0;
            tpSck  <= ~tpSck;
            if (tpSck) begin
              if (lastBit) begin
                state   <= TP_WAIT;
                tpCsN   <= 1'b1;
                done    <= 1'b1;
                rateCnt <= RATE_LOAD;
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= TP_WAIT;
      endcase
    end
  end

  // Independent tally of cycles since the serial clock last moved
  logic [DIV_W-1:0] sinceToggle;
  always_ff @(posedge clk) begin
    if (!rstN || strobes.load || strobes.capture || strobes.advance || strobes.publish)
      sinceToggle <= '0;
    else if (sinceToggle != {DIV_W{1'b1}})
      sinceToggle <= sinceToggle + 1'b1;
  end

  assert_sck_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    tpCsN |-> !tpSck);

  assert_half_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tpSck) |-> ($past(sinceToggle) == DIV_LAST));

  assert_done_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (tpCsN && !$past(tpCsN)));

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (slotReq && !slotGrant) |=> slotReq);

  assert_grant_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tpCsN) |-> $past(slotReq && slotGrant));

endmodule

// File: rtl/touch_xyz_datapath.sv
module touch_xyz_datapath
  import touch_xyz_pkg::*;
#(
  parameter int XFER_BITS   = 51,
  parameter int RX_WORD     = 15,
  parameter int RESULT_BITS = 12,
  parameter int NUM_RESULTS = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  tpStrobes_t                         strobes,
  input  logic [XFER_BITS-1:0]               cmdStream,
  input  logic                               tpMiso,
  output logic                               tpMosi,
  output logic [NUM_RESULTS*RESULT_BITS-1:0] resultsFlat,
  output logic                               sampleValid
);

  localparam int RX_TOTAL = (NUM_RESULTS + 1) * RX_WORD;
  localparam int PREFILL  = RX_TOTAL - XFER_BITS;
  localparam int CNT_W    = $clog2(XFER_BITS + 1);

  logic [XFER_BITS-1:0] txShift;
  logic [RX_TOTAL-1:0]  rxShift;
  logic [CNT_W-1:0]     capCnt;

  assign tpMosi = txShift[XFER_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      capCnt  <= '0;
    end else if (strobes.load) begin
      txShift <= cmdStream;
      rxShift <= {RX_TOTAL{1'b0}};   // the PREFILL top bits stay zero
      capCnt  <= '0;
    end else begin
      if (strobes.advance) txShift <= {txShift[XFER_BITS-2:0], 1'b0};
      if (strobes.capture) begin
        rxShift <= {rxShift[RX_TOTAL-2:0], tpMiso};
        capCnt  <= capCnt + 1'b1;
      end
    end
  end

  // Frame 0 is discarded; frame g+1 feeds result g from its upper bits
  for (genvar g = 0; g < NUM_RESULTS; g++) begin : gResult
    localparam int FRAME_TOP = RX_TOTAL - 1 - (g + 1) * RX_WORD;
    always_ff @(posedge clk) begin
      if (!rstN)
        resultsFlat[(NUM_RESULTS-g)*RESULT_BITS-1 -: RESULT_BITS] <= '0;
      else if (strobes.publish)
        resultsFlat[(NUM_RESULTS-g)*RESULT_BITS-1 -: RESULT_BITS] <=
          rxShift[FRAME_TOP -: RESULT_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) sampleValid <= 1'b0;
    else       sampleValid <= strobes.publish;
  end

  assert_bit_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.publish |-> (capCnt == CNT_W'(XFER_BITS)));

  assert_prefill_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.publish |-> (rxShift[RX_TOTAL-1 -: PREFILL] == '0));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  assert_results_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(resultsFlat));

endmodule

// File: rtl/touch_xyz_sampler.sv
module touch_xyz_sampler
  import touch_xyz_pkg::*;
#(
  parameter int HALF_DIV    = 40,
  parameter int RATE_CYCLES = 500000,
  parameter int CMD_WORD    = 17,
  parameter int CMD_WORDS   = 3,
  parameter int RX_WORD     = 15,
  parameter int RESULT_BITS = 12
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             slotGrant,
  input  logic [CMD_WORD*CMD_WORDS-1:0]    cmdStream,
  input  logic                             tpMiso,
  output logic                             slotReq,
  output logic                             tpCsN,
  output logic                             tpSck,
  output logic                             tpMosi,
  output logic                             done,
  output logic                             sampleValid,
  output logic [RESULT_BITS-1:0]           sampleX,
  output logic [RESULT_BITS-1:0]           sampleY,
  output logic [RESULT_BITS-1:0]           sampleZ
);

  localparam int XFER_BITS   = CMD_WORD * CMD_WORDS;
  localparam int NUM_RESULTS = 3;

  tpStrobes_t                         strobes;
  logic [NUM_RESULTS*RESULT_BITS-1:0] resultsFlat;

  touch_xyz_ctrl #(
    .HALF_DIV   (HALF_DIV),
    .RATE_CYCLES(RATE_CYCLES),
    .XFER_BITS  (XFER_BITS)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .slotGrant(slotGrant),
    .slotReq  (slotReq),
    .tpCsN    (tpCsN),
    .tpSck    (tpSck),
    .done     (done),
    .strobes  (strobes)
  );

  touch_xyz_datapath #(
    .XFER_BITS  (XFER_BITS),
    .RX_WORD    (RX_WORD),
    .RESULT_BITS(RESULT_BITS),
    .NUM_RESULTS(NUM_RESULTS)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cmdStream  (cmdStream),
    .tpMiso     (tpMiso),
    .tpMosi     (tpMosi),
    .resultsFlat(resultsFlat),
    .sampleValid(sampleValid)
  );

  assign sampleX = resultsFlat[3*RESULT_BITS-1 -: RESULT_BITS];
  assign sampleY = resultsFlat[2*RESULT_BITS-1 -: RESULT_BITS];
  assign sampleZ = resultsFlat[RESULT_BITS-1   -: RESULT_BITS];

endmodule

// File: tb/tb_touch_xyz_sampler.sv
module tb_touch_xyz_sampler;

  localparam int HALF_DIV = 3;
  localparam int RATE     = 500;
  localparam int NTRANS   = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slotGrant = 1'b0;
  logic [50:0] cmdStream = '0;
  logic        tpMiso = 1'b0;
  logic        slotReq, tpCsN, tpSck, tpMosi, done, sampleValid;
  logic [11:0] sampleX, sampleY, sampleZ;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  touch_xyz_sampler #(.HALF_DIV(HALF_DIV), .RATE_CYCLES(RATE)) dut (
    .clk(clk), .rstN(rstN), .slotGrant(slotGrant), .cmdStream(cmdStream),
    .tpMiso(tpMiso), .slotReq(slotReq), .tpCsN(tpCsN), .tpSck(tpSck),
    .tpMosi(tpMosi), .done(done), .sampleValid(sampleValid),
    .sampleX(sampleX), .sampleY(sampleY), .sampleZ(sampleZ)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reply stream seen on the input line: index 50-i holds serial cycle i
  function automatic logic [50:0] buildReply(input logic [11:0] x, input logic [11:0] y,
                                             input logic [11:0] z, input logic [50:0] junk);
    logic [50:0] r;
    r = junk;
    r[44:33] = x;   // cycles 6..17
    r[29:18] = y;   // cycles 21..32
    r[14:3]  = z;   // cycles 36..47
    return r;
  endfunction

  task automatic waitForReq(input bit checkInterval, input bit stray);
    int cnt = 0;
    bit started = 1'b0;
    logic [11:0] hx = sampleX, hy = sampleY, hz = sampleZ;
    while (!slotReq && cnt < RATE + 10) begin
      slotGrant = (stray && cnt == 5);
      @(negedge clk);
      cnt++;
      if (!tpCsN) started = 1'b1;
      if (cnt == 1 && checkInterval) begin
        check(!sampleValid, "R7 valid one cycle", sampleValid, 0);
        check(sampleX == hx && sampleY == hy && sampleZ == hz, "R7 results hold",
              {sampleX, sampleY, sampleZ}, {hx, hy, hz});
      end
    end
    slotGrant = 1'b0;
    if (checkInterval) check(cnt == RATE, "R8 request interval", cnt, RATE);
    if (stray) check(!started, "R9 stray grant ignored", started, 0);
  endtask

  task automatic runXfer(input logic [50:0] cmd, input logic [11:0] x, input logic [11:0] y,
                         input logic [11:0] z, input logic [50:0] junk, input bit hold);
    logic [50:0] reply = buildReply(x, y, z, junk);
    int mosiErr = 0;
    int rises = 0;
    int lowCnt = 0;
    bit prevLow = 1'b0;
    int dly = $urandom_range(0, 6);
    repeat (dly) @(negedge clk);
    check(slotReq, "R8 request held until grant", slotReq, 1);
    cmdStream = cmd;
    tpMiso = reply[50];
    slotGrant = 1'b1;
    fork
      begin
        for (int i = 0; i < 51; i++) begin
          @(posedge tpSck); #1;
          rises++;
          if (tpMosi !== cmd[50-i]) mosiErr++;
          @(negedge tpSck); #1;
          if (i < 50) tpMiso = reply[49-i];
        end
      end
      begin
        @(negedge clk);
        if (!hold) slotGrant = 1'b0;
        cmdStream = ~cmd;  // must not disturb a latched stream (R3)
        while (!done && lowCnt < 2000) begin
          prevLow = !tpCsN;
          if (!tpCsN) lowCnt++;
          @(negedge clk);
        end
      end
    join
    slotGrant = 1'b0;
    check(rises == 51, "R1 serial rising edges", rises, 51);
    check(lowCnt == 102 * HALF_DIV, "R2 chip-select low cycles", lowCnt, 102 * HALF_DIV);
    check(mosiErr == 0, "R3 command bits", mosiErr, 0);
    check(done && tpCsN && prevLow, "R6 done with chip-select rise", {done, tpCsN, prevLow}, 3'b111);
    check(!tpSck, "R1 clock idle low", tpSck, 0);
    check(sampleValid, "R7 valid with done", sampleValid, 1);
    check(sampleX == x, "R5 X result", sampleX, x);
    check(sampleY == y, "R5 Y result", sampleY, y);
    check(sampleZ == z, "R5 Z result / R4 framing", sampleZ, z);
  endtask

  initial begin
    void'($urandom(32'd7731));
    repeat (4) @(negedge clk);
    check(tpCsN && !tpSck && !tpMosi && !slotReq && !done && !sampleValid, "R10 outputs in reset",
          {tpCsN, tpSck, tpMosi, slotReq, done, sampleValid}, 6'b100000);
    check(sampleX == 0 && sampleY == 0 && sampleZ == 0, "R10 results in reset",
          {sampleX, sampleY, sampleZ}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(tpCsN && !slotReq && !done, "R10 state after reset", {tpCsN, slotReq, done}, 3'b100);
    waitForReq(1'b0, 1'b1);
    for (int t = 0; t < NTRANS; t++) begin
      logic [50:0] cmd = 51'({$urandom(), $urandom()});
      logic [50:0] junk = 51'({$urandom(), $urandom()});
      logic [11:0] x = 12'($urandom());
      logic [11:0] y = 12'($urandom());
      logic [11:0] z = 12'($urandom());
      if (t == 0) begin x = 12'h000; y = 12'h000; z = 12'h000; junk = '1; cmd = '1; end
      if (t == 1) begin x = 12'hFFF; y = 12'hFFF; z = 12'hFFF; junk = '0; cmd = '0; end
      if (t == 2) begin x = 12'h800; y = 12'h001; z = 12'hA5A; cmd = 51'h5_5555_5555_5555; end
      runXfer(cmd, x, y, z, junk, (t % 5) == 3);  // held grant tests R9 during transfer
      waitForReq(1'b1, (t % 4) == 1);
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule